// File: doc/BRIEF.md
# Multi-Mode Parallel LCD Bus Controller

This block lets a host talk to an external LCD panel over a parallel bus, one transaction at a time. The host raises a request with a data word, a read/write flag, a command-or-data flag and a display number (0 or 1). The controller then runs a setup period, a strobe period and a hold period, each of a programmable number of clocks, on the panel pins. It finishes with a one-clock acknowledge, and for reads it returns the sampled data.

A 3-bit mode input picks the protocol. Code 0 is 6800-style with a synchronous clock, 1 is 6800-style asynchronous, 2 is 8080-style with a synchronous clock, 3 is 8080-style asynchronous, and 4 is character-display style. Five shared control pins take a different meaning in each mode. Character mode has an 8-bit bus, or a 4-bit variant that moves each byte as two strobes. The second display is reached through a per-mode chip-select or enable pin. In the synchronous variants that pin carries a free-running clock instead.

Top module: `lcd_pbus_ctrl`

## Requirements
- R1: Mode codes are 0 = 6800 synchronous, 1 = 6800 asynchronous, 2 = 8080 synchronous, 3 = 8080 asynchronous, 4 = character. Codes 5 to 7 behave as code 4. Mode, width select, timing and request fields are latched when a request is accepted, so changing them during a transaction has no effect on it.
- R2: A request is accepted only on a clock edge where the block is idle. `req_busy` is high from the cycle after acceptance up to and including the acknowledge cycle. A request raised while busy, including during the acknowledge cycle, is ignored.
- R3: After acceptance the block holds `cfg_setup` setup cycles, then `cfg_strobe` strobe cycles, then `cfg_hold` hold cycles. A value of 0 counts as 1. These are followed by exactly one cycle with `req_ack` high.
- R4: In character mode, `lcd_p_sel0` (enable for display 0) and `lcd_p_sel1` (enable for display 1) are active high and pulse only during strobe cycles, for the addressed display. `lcd_p_dir` is 1 for a read. `lcd_p_rs` is 1 for data and 0 for command. Both of these hold their value through setup, strobe and hold. `lcd_p_strb` stays 0.
- R5: In 6800 modes, `lcd_p_strb` is an active-high enable during strobe cycles, and `lcd_p_dir` is 1 for a read throughout the transaction. `lcd_p_sel0` and `lcd_p_sel1` are active-low chip selects for displays 0 and 1, held low for the whole setup-strobe-hold span. `lcd_p_rs` carries the command/data flag.
- R6: In 8080 modes, `lcd_p_strb` is an active-low read strobe and `lcd_p_dir` is an active-low write strobe. Only the one matching the transaction goes low, and only during strobe cycles. Chip selects and `lcd_p_rs` behave as in R5.
- R7: In modes 0 and 2, `lcd_p_sel1` is a free-running clock that toggles every `SCLK_HALF` clocks, idle or busy. In these modes the display field is ignored and `lcd_p_sel0` selects the panel.
- R8: During setup, strobe and hold of a write, `lcd_d_oe` is 1. In bus modes all 16 lines carry the word. In 8-bit character mode bits 7:0 carry the low byte and the other lines are 0. During reads, in the acknowledge cycle and when idle, `lcd_d_oe` is 0 and `lcd_d_out` is 0.
- R9: In 4-bit character mode (`cfg_nib4` = 1), a byte takes two full setup-strobe-hold passes before the single acknowledge. The high nibble goes first, then the low nibble, and each is driven on bits 7:4 with all other lines 0.
- R10: Read data is sampled at the clock edge that ends the last strobe cycle. `rsp_rdata` holds the result in the acknowledge cycle. Bus modes return all 16 lines. 8-bit character mode returns lines 7:0 in bits 7:0. 4-bit character mode returns the first nibble from lines 7:4 in bits 7:4 and the second in bits 3:0. Unused upper bits are 0.
- R11: Between transactions every control pin sits at its inactive level. In character mode that is all five pins at 0. In 6800 modes, strobe, direction and register select are 0 and the chip selects are 1. In 8080 modes, strobe, direction and both chip selects are 1 and register select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Protocol code |
| cfg_nib4 | input | 1 | 4-bit width in character mode |
| cfg_setup | input | 4 | Setup cycles |
| cfg_strobe | input | 4 | Strobe-width cycles |
| cfg_hold | input | 4 | Hold cycles |
| req_valid | input | 1 | Host transaction request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_data_sel | input | 1 | 1 = data, 0 = command |
| req_disp | input | 1 | Target display |
| req_wdata | input | 16 | Write word |
| req_busy | output | 1 | Transaction in progress |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result |
| lcd_d_out | output | 16 | Panel data out |
| lcd_d_oe | output | 1 | Panel data output enable |
| lcd_d_in | input | 16 | Panel data in |
| lcd_p_strb | output | 1 | Enable clock / read strobe |
| lcd_p_dir | output | 1 | Read-write level / write strobe |
| lcd_p_rs | output | 1 | Command or data select |
| lcd_p_sel0 | output | 1 | Chip select 0 / enable 0 |
| lcd_p_sel1 | output | 1 | Chip select 1 / enable 1 / sync clock |

## Verification
All pin outputs come straight from the phase register. The first setup cycle therefore appears in the cycle after the accepting edge, the strobe begins S cycles later, and the acknowledge arrives S+W+H+1 cycles after acceptance (2·(S+W+H)+1 in 4-bit character mode). Read data is captured at the edge that closes the last strobe cycle and is checked on `rsp_rdata` in the acknowledge cycle. The bench keeps a queue with one expected entry per clock, pushed when a request is accepted, and compares every output on each falling edge against the head entry, or against the idle levels when the queue is empty. It drives wrong read data on every strobe cycle except the last, so sampling on any other cycle is caught.

// File: rtl/lcd_pbus_pkg.sv
// Shared types and mode helpers for the parallel LCD bus controller.
// Assumes mode codes: 0/1 = 6800 sync/async, 2/3 = 8080 sync/async, 4..7 = character.
package lcd_pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        FAM_CHAR = 2'd0,
        FAM_M68  = 2'd1,
        FAM_I80  = 2'd2
    } family_t;

    // Protocol family of a mode code.
    function automatic family_t mode_family(input logic [2:0] m);
        if (m[2])      return FAM_CHAR;
        else if (m[1]) return FAM_I80;
        else           return FAM_M68;
    endfunction

    // Synchronous-clock variant (codes 0 and 2).
    function automatic logic mode_sync(input logic [2:0] m);
        return ~m[2] & ~m[0];
    endfunction

endpackage

// File: rtl/lcd_pbus_seq.sv
// Phase sequencer: setup -> strobe -> hold (twice when two_pass) -> done.
// Assumes timing counts are latched at start; a zero count is treated as one clock.
module lcd_pbus_seq
    import lcd_pbus_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          two_pass,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_strobe,
    input  logic [TW-1:0] t_hold,
    output phase_t        phase,
    output logic          second,
    output logic          last_strobe
);

    logic [TW-1:0] cnt;
    logic [TW-1:0] ts_l, tw_l, th_l;
    logic          two_l;

    // Remaining-cycle load value for a programmed count (minimum one clock).
    function automatic logic [TW-1:0] load_of(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Phase transitions and per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            second <= 1'b0;
            ts_l   <= '0;
            tw_l   <= '0;
            th_l   <= '0;
            two_l  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_SETUP;
                    cnt    <= load_of(t_setup);
                    ts_l   <= t_setup;
                    tw_l   <= t_strobe;
                    th_l   <= t_hold;
                    two_l  <= two_pass;
                    second <= 1'b0;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_STROBE;
                    cnt   <= load_of(tw_l);
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= load_of(th_l);
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) begin
                    if (two_l && !second) begin
                        phase  <= PH_SETUP;
                        cnt    <= load_of(ts_l);
                        second <= 1'b1;
                    end else begin
                        phase <= PH_DONE;
                    end
                end else cnt <= cnt - 1'b1;
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Marks the final clock of the strobe period (read sampling point).
    always_comb last_strobe = (phase == PH_STROBE) && (cnt == '0);

    AST_START_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (phase == PH_SETUP)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE)); // R3
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_SETUP || phase == PH_DONE)); // R3
    AST_TWO_PASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && two_l) |-> second); // R9

endmodule

// File: rtl/lcd_pbus_sclk.sv
// Free-running clock for the synchronous bus variants.
// Assumes HALF >= 1; the output toggles every HALF input clocks.
module lcd_pbus_sclk #(
    parameter int HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Divide-and-toggle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_pbus_pinmap.sv
// Pin mapper: turns phase plus latched request into the five shared control
// pins and the data bus for the selected protocol family. Purely combinational.
// Assumes DW >= 8; character mode uses the low byte lanes only.
module lcd_pbus_pinmap
    import lcd_pbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  family_t       fam,
    input  logic          sync,
    input  logic          active,
    input  logic          strobing,
    input  logic          rd,
    input  logic          dc,
    input  logic          disp,
    input  logic          nib4,
    input  logic          second,
    input  logic          sclk,
    input  logic [DW-1:0] wdata,
    output logic          p_strb,
    output logic          p_dir,
    output logic          p_rs,
    output logic          p_sel0,
    output logic          p_sel1,
    output logic          d_oe,
    output logic [DW-1:0] d_out
);

    localparam int CW  = 8;
    localparam int NIB = CW / 2;

    logic          tgt1;
    logic [NIB-1:0] nib_val;

    // Control pin meaning per family.
    always_comb begin
        tgt1   = disp & ~sync;
        p_rs   = active & dc;
        p_sel0 = ~(active & ~tgt1);
        p_sel1 = sync ? sclk : ~(active & tgt1);
        p_strb = 1'b0;
        p_dir  = active & rd;
        unique case (fam)
            FAM_CHAR: begin
                p_sel0 = strobing & ~disp;
                p_sel1 = strobing & disp;
            end
            FAM_M68: begin
                p_strb = strobing;
            end
            default: begin
                p_strb = ~(strobing & rd);
                p_dir  = ~(strobing & ~rd);
            end
        endcase
    end

    // Data lane selection and output enable.
    always_comb begin
        d_oe    = active & ~rd;
        nib_val = second ? wdata[NIB-1:0] : wdata[CW-1:NIB];
        d_out   = '0;
        if (d_oe) begin
            if (fam != FAM_CHAR)  d_out = wdata;
            else if (nib4)        d_out[CW-1:NIB] = nib_val;
            else                  d_out[CW-1:0] = wdata[CW-1:0];
        end
    end

endmodule

// File: rtl/lcd_pbus_ctrl.sv
// Multi-mode parallel LCD bus controller top. Accepts one host request when
// idle, latches it, runs the phase sequencer, maps pins per mode and captures
// read data. Assumes the host holds request fields valid with req_valid.
module lcd_pbus_ctrl
    import lcd_pbus_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TW        = 4,
    parameter int SCLK_HALF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_mode,
    input  logic          cfg_nib4,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_strobe,
    input  logic [TW-1:0] cfg_hold,
    input  logic          req_valid,
    input  logic          req_read,
    input  logic          req_data_sel,
    input  logic          req_disp,
    input  logic [DW-1:0] req_wdata,
    output logic          req_busy,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [DW-1:0] lcd_d_out,
    output logic          lcd_d_oe,
    input  logic [DW-1:0] lcd_d_in,
    output logic          lcd_p_strb,
    output logic          lcd_p_dir,
    output logic          lcd_p_rs,
    output logic          lcd_p_sel0,
    output logic          lcd_p_sel1
);

    localparam int CW  = 8;
    localparam int NIB = CW / 2;

    phase_t        phase;
    logic          second, last_strobe, sclk, accept;
    logic [2:0]    mode_l, mode_eff;
    logic          nib4_l, rd_l, dc_l, disp_l;
    logic [DW-1:0] wdata_l;
    family_t       fam;
    logic          sync_eff, active, strobing;

    // Request acceptance.
    always_comb accept = req_valid && (phase == PH_IDLE);

    // Latch request and mode at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_l  <= 3'd4;
            nib4_l  <= 1'b0;
            rd_l    <= 1'b0;
            dc_l    <= 1'b0;
            disp_l  <= 1'b0;
            wdata_l <= '0;
        end else if (accept) begin
            mode_l  <= cfg_mode;
            nib4_l  <= cfg_nib4;
            rd_l    <= req_read;
            dc_l    <= req_data_sel;
            disp_l  <= req_disp;
            wdata_l <= req_wdata;
        end
    end

    // Effective mode: latched while busy, live when idle.
    always_comb begin
        mode_eff = req_busy ? mode_l : cfg_mode;
        fam      = mode_family(mode_eff);
        sync_eff = mode_sync(mode_eff);
        active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobing = (phase == PH_STROBE);
        req_busy = (phase != PH_IDLE);
        req_ack  = (phase == PH_DONE);
    end

    lcd_pbus_seq #(.TW(TW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .two_pass    (cfg_nib4 && cfg_mode[2]),
        .t_setup     (cfg_setup),
        .t_strobe    (cfg_strobe),
        .t_hold      (cfg_hold),
        .phase       (phase),
        .second      (second),
        .last_strobe (last_strobe)
    );

    lcd_pbus_sclk #(.HALF(SCLK_HALF)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk)
    );

    lcd_pbus_pinmap #(.DW(DW)) u_pins (
        .fam      (fam),
        .sync     (sync_eff),
        .active   (active),
        .strobing (strobing),
        .rd       (rd_l),
        .dc       (dc_l),
        .disp     (disp_l),
        .nib4     (nib4_l),
        .second   (second),
        .sclk     (sclk),
        .wdata    (wdata_l),
        .p_strb   (lcd_p_strb),
        .p_dir    (lcd_p_dir),
        .p_rs     (lcd_p_rs),
        .p_sel0   (lcd_p_sel0),
        .p_sel1   (lcd_p_sel1),
        .d_oe     (lcd_d_oe),
        .d_out    (lcd_d_out)
    );

    // Read capture on the final strobe clock, per family and width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (last_strobe && rd_l) begin
            if (fam != FAM_CHAR) begin
                rsp_rdata <= lcd_d_in;
            end else if (!nib4_l) begin
                rsp_rdata <= {{(DW-CW){1'b0}}, lcd_d_in[CW-1:0]};
            end else if (!second) begin
                rsp_rdata <= {{(DW-CW){1'b0}}, lcd_d_in[CW-1:NIB], {NIB{1'b0}}};
            end else begin
                rsp_rdata[NIB-1:0] <= lcd_d_in[CW-1:NIB];
            end
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && rd_l) |-> !lcd_d_oe); // R8
    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (fam != FAM_CHAR && !sync_eff) |-> ($countones({~lcd_p_sel0, ~lcd_p_sel1}) <= 1)); // R5
    AST_I80_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fam == FAM_I80) |-> (lcd_p_strb || lcd_p_dir)); // R6
    AST_CHAR_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fam == FAM_CHAR) |-> $onehot0({lcd_p_sel0, lcd_p_sel1})); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_busy) |-> (!lcd_d_oe && !lcd_p_rs)); // R11

endmodule

// File: tb/lcd_pbus_ctrl_test.sv
// Bench: per-clock expectation queue filled at acceptance, compared on falling edges.
module lcd_pbus_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int ph;     // 1 setup, 2 strobe, 3 hold, 4 ack
        bit sec;
        bit last;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd4;
    logic cfg_nib4 = 1'b0;
    logic [3:0] cfg_setup = 4'd1, cfg_strobe = 4'd1, cfg_hold = 4'd1;
    logic req_valid = 1'b0, req_read = 1'b0, req_data_sel = 1'b0, req_disp = 1'b0;
    logic [15:0] req_wdata = '0, lcd_d_in = '0;
    logic req_busy, req_ack, lcd_d_oe;
    logic [15:0] rsp_rdata, lcd_d_out;
    logic lcd_p_strb, lcd_p_dir, lcd_p_rs, lcd_p_sel0, lcd_p_sel1;

    int n_chk = 0, n_fail = 0;
    ent_t q[$];
    int t_mode; bit t_w4, t_rd, t_dc, t_disp;
    logic [15:0] t_wd, t_rw;
    bit prev_sync = 0; logic prev_sel1 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_nib4(cfg_nib4),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .req_valid(req_valid), .req_read(req_read), .req_data_sel(req_data_sel),
        .req_disp(req_disp), .req_wdata(req_wdata), .req_busy(req_busy),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .lcd_d_out(lcd_d_out),
        .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in), .lcd_p_strb(lcd_p_strb),
        .lcd_p_dir(lcd_p_dir), .lcd_p_rs(lcd_p_rs), .lcd_p_sel0(lcd_p_sel0),
        .lcd_p_sel1(lcd_p_sel1)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: compare all outputs with the head expectation, then drive read lines.
    task automatic step();
        ent_t e;
        bit have, act, stb, rd, dc, disp, sync, ack;
        int md;
        logic e_strb, e_dir, e_rs, e_s0, e_s1, e_oe;
        logic [15:0] e_d;
        string tag;
        @(negedge clk);
        have = (q.size() > 0);
        if (have) e = q.pop_front(); else e = '{0, 0, 0};
        md   = have ? t_mode : int'(cfg_mode);
        act  = have && e.ph != 4;
        stb  = have && e.ph == 2;
        rd   = have && t_rd;
        dc   = have && t_dc;
        sync = (md == 0 || md == 2);
        disp = have && t_disp && !sync;
        ack  = have && e.ph == 4;
        e_rs = act && dc;
        if (md >= 4) begin
            tag = have ? "R4" : "R11";
            e_strb = 0; e_dir = act && rd;
            e_s0 = stb && !(have && t_disp); e_s1 = stb && have && t_disp;
        end else begin
            tag = !have ? "R11" : (md >= 2 ? "R6" : "R5");
            e_s0 = !(act && !disp); e_s1 = !(act && disp);
            if (md >= 2) begin
                e_strb = !(stb && rd); e_dir = !(stb && !rd);
            end else begin
                e_strb = stb; e_dir = act && rd;
            end
        end
        chk({lcd_p_strb, lcd_p_dir, lcd_p_rs, lcd_p_sel0} === {e_strb, e_dir, e_rs, e_s0},
            tag, "ctl", 32'({lcd_p_strb, lcd_p_dir, lcd_p_rs, lcd_p_sel0}),
            32'({e_strb, e_dir, e_rs, e_s0}));
        if (!sync) chk(lcd_p_sel1 === e_s1, tag, "sel1", 32'(lcd_p_sel1), 32'(e_s1));
        else if (prev_sync) chk(lcd_p_sel1 === ~prev_sel1, "R7", "sclk", 32'(lcd_p_sel1), 32'(~prev_sel1));
        prev_sync = sync; prev_sel1 = lcd_p_sel1;
        e_oe = act && !rd;
        e_d = '0;
        if (e_oe) begin
            if (md < 4) e_d = t_wd;
            else if (t_w4) e_d[7:4] = e.sec ? t_wd[3:0] : t_wd[7:4];
            else e_d[7:0] = t_wd[7:0];
        end
        chk({lcd_d_oe, lcd_d_out} === {e_oe, e_d}, (md >= 4 && t_w4 && have) ? "R9" : "R8",
            "data", 32'({lcd_d_oe, lcd_d_out}), 32'({e_oe, e_d}));
        chk({req_busy, req_ack} === {have, ack}, have ? "R3" : "R2", "hs",
            32'({req_busy, req_ack}), 32'({have, ack}));
        if (ack && t_rd) begin
            logic [15:0] e_r;
            e_r = (md < 4) ? t_rw : {8'h00, t_rw[7:0]};
            chk(rsp_rdata === e_r, "R10", "rdata", 32'(rsp_rdata), 32'(e_r));
        end
        if (stb && e.last) begin
            if (md < 4) lcd_d_in = t_rw;
            else if (t_w4) lcd_d_in = {8'hA5, e.sec ? t_rw[3:0] : t_rw[7:4], 4'h9};
            else lcd_d_in = {8'h5A, t_rw[7:0]};
        end else begin
            lcd_d_in = ~t_rw;
        end
    endtask

    // Fill expectation queue for an accepted request (R1 latching, R3 counts, R9 passes).
    task automatic expect_txn(input int s, input int w, input int h);
        int passes;
        passes = (t_mode >= 4 && t_w4) ? 2 : 1;
        if (s == 0) s = 1;
        if (w == 0) w = 1;
        if (h == 0) h = 1;
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < s; i++) q.push_back('{1, p == 1, 0});
            for (int i = 0; i < w; i++) q.push_back('{2, p == 1, i == w - 1});
            for (int i = 0; i < h; i++) q.push_back('{3, p == 1, 0});
        end
        q.push_back('{4, 0, 0});
    endtask

    task automatic launch(input int md, input bit w4, input bit rd, input bit dc, input bit dp,
                          input logic [15:0] wd, input logic [15:0] rw,
                          input int s, input int w, input int h);
        cfg_mode = 3'(md); cfg_nib4 = w4; cfg_setup = 4'(s); cfg_strobe = 4'(w); cfg_hold = 4'(h);
        req_read = rd; req_data_sel = dc; req_disp = dp; req_wdata = wd; req_valid = 1'b1;
        t_mode = md; t_w4 = w4; t_rd = rd; t_dc = dc; t_disp = dp; t_wd = wd; t_rw = rw;
        expect_txn(s, w, h);
        step();
        req_valid = 1'b0;
    endtask

    task automatic run(input int md, input bit w4, input bit rd, input bit dc, input bit dp,
                       input logic [15:0] wd, input logic [15:0] rw,
                       input int s, input int w, input int h);
        launch(md, w4, rd, dc, dp, wd, rw, s, w, h);
        while (q.size() > 0) step();
        step(); step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_mode = 4; t_w4 = 0; t_rd = 0; t_dc = 0; t_disp = 0; t_wd = '0; t_rw = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(); // reset state, R11
        chk(rsp_rdata === 16'h0, "R10", "reset rdata", 32'(rsp_rdata), 32'h0);
        run(4, 0, 0, 1, 0, 16'h12C3, 16'h0, 2, 3, 1);      // R4 R8 char8 write
        run(4, 0, 1, 0, 1, 16'h0, 16'hBE7E, 1, 3, 2);      // R4 R10 char8 read
        run(4, 1, 0, 1, 0, 16'h00A6, 16'h0, 1, 2, 2);      // R9 char4 write
        run(4, 1, 1, 1, 1, 16'h0, 16'h003C, 2, 2, 1);      // R9 R10 char4 read
        run(1, 0, 0, 0, 1, 16'hF00D, 16'h0, 0, 0, 0);      // R5 R3 zeros count as one
        run(1, 0, 1, 1, 0, 16'h0, 16'hC0DE, 3, 4, 2);      // R5 R10 6800 read
        run(3, 0, 0, 1, 0, 16'h8421, 16'h0, 1, 2, 1);      // R6 8080 write
        run(3, 0, 1, 0, 1, 16'h0, 16'h7A5B, 2, 3, 2);      // R6 R10 8080 read
        run(0, 0, 0, 1, 1, 16'h3344, 16'h0, 1, 2, 1);      // R7 6800 sync, display ignored
        run(2, 0, 1, 0, 1, 16'h0, 16'h9911, 2, 2, 2);      // R7 8080 sync read
        run(6, 0, 0, 0, 1, 16'h55AA, 16'h0, 1, 1, 1);      // R1 code 6 acts as char
        run(3, 0, 0, 0, 0, 16'hFFFF, 16'h0, 15, 15, 15);   // R3 maximum counts
        // R2 and R1: request and mode changes while busy are ignored
        launch(1, 0, 0, 1, 0, 16'h1357, 16'h0, 2, 2, 2);
        step();
        cfg_mode = 3'd3; req_valid = 1'b1; req_read = 1'b1; req_wdata = 16'hDEAD;
        cfg_setup = 4'd7;
        while (q.size() > 0) step();
        req_valid = 1'b0;
        step(); step(); // idle in live 8080 mode, R11
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule